// File: doc/BRIEF.md
# One-Hot Step Sequencer with Per-Step Modes

The block keeps a one-hot step pointer. The pointer moves forward one position on each rising edge of an asynchronous step clock, `tick_in`. Both `tick_in` and the asynchronous restart request `restart_in` pass through a multi-stage synchronizer into the system clock domain. The block acts only on the detected rising edge of each signal. Holding either input high therefore causes exactly one action and cannot stall the pointer.

Each step carries a two-bit mode: play, mute, or jump-home. A play step opens the gate output only while the synchronized step clock is high. A run of play steps therefore gives separate gate pulses rather than one merged level. A mute step lets the pointer pass through with the gate held low. A jump-home step sends the pointer straight back to step 0 on the same advance. This is how a 16-step instance is cut down to 8 or 10 steps.

A trigger output pulses for one system clock whenever a play step becomes active. A carry output pulses for one system clock when the pointer leaves the last step, so a second instance can be driven from it.

Top module: `stepseq_top`

## Requirements
- R1: `step_onehot_o` always has exactly one bit set. After `rst_n` is asserted, that bit is bit 0 (step 0), and `gate_o`, `trig_o` and `carry_o` are low.
- R2: A low-to-high transition of `tick_in` moves the pointer from step i to step i+1, and from the last step to step 0. The new pointer value appears after SYNC_STAGES+1 system clock edges, counted from the first edge that samples `tick_in` high (3 edges with the defaults). Holding `tick_in` high causes only that one advance.
- R3: The mode of step i is `step_mode_i[2*i+1:2*i]`. Code 00 is play, 01 is mute, 10 is jump-home and 11 is mute. Only code 00 ever lets `gate_o` or `trig_o` go high.
- R4: `gate_o` is high only while the synchronized step clock is high and the current step is in play mode. When `tick_in` is held high for H system cycles, the gate is high for exactly H cycles. It goes low between consecutive play steps.
- R5: An advance whose target step is in jump-home mode puts the pointer on step 0 instead, on that same advance. If every step is in jump-home mode, the pointer stays at step 0 and no gate or trigger is produced.
- R6: `trig_o` is high for exactly one system cycle: the cycle in which a new pointer value first appears after an advance or a restart, provided the new step is in play mode.
- R7: `carry_o` is high for exactly one system cycle, in the cycle the pointer first shows step 0 after advancing out of the last step. It never comes from a restart.
- R8: A rising edge of `restart_in` puts the pointer on step 0, with the same latency as R2. Keeping `restart_in` high afterwards has no further effect, and step advances continue normally.
- R9: When a restart edge and a step-clock edge are detected in the same system cycle, the restart wins. The pointer goes to step 0 and no carry is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Asynchronous step clock; each rising edge advances the pointer |
| restart_in | input | 1 | Asynchronous restart request; each rising edge returns the pointer to step 0 |
| step_mode_i | input | 2*NUM_STEPS | Two-bit mode per step (00 play, 01 mute, 10 jump-home, 11 mute) |
| step_onehot_o | output | NUM_STEPS | One-hot active step |
| gate_o | output | 1 | Step clock qualified by the play mode of the current step |
| trig_o | output | 1 | One-cycle pulse when a play step becomes active |
| carry_o | output | 1 | One-cycle pulse when the pointer wraps past the last step |

## Verification
The bench uses a 4-step configuration. It sweeps all 256 combinations of the two-bit step codes and runs each for more than two full laps. This separates play from both mute codes, shows where jump-home shortens the loop, and covers the all-jump-home lock at step 0. Each advance is sampled at the first cycle, the second cycle, the last high cycle and the first low cycle of the gate. These samples tell a gate that follows the step clock apart from one that follows the step level, and a trigger or carry pulse apart from a held level. Odd-numbered patterns keep the restart level high through the whole run, which shows it does not freeze the pointer. Separate cases apply a restart and a step edge in the same cycle, and a reset in the middle of a run.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

   typedef enum logic [1:0] {
      MODE_PLAY      = 2'b00,
      MODE_MUTE      = 2'b01,
      MODE_HOME      = 2'b10,
      MODE_MUTE_ALT  = 2'b11
   } step_mode_e;

   localparam int MODE_BITS = 2;

   function automatic logic mode_plays(input logic [MODE_BITS-1:0] code);
      return code == MODE_PLAY;
   endfunction

   function automatic logic mode_homes(input logic [MODE_BITS-1:0] code);
      return code == MODE_HOME;
   endfunction

endpackage

// File: rtl/stepseq_sync.sv
module stepseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic lvl_o,
   output logic rise_o
);

   logic [STAGES-1:0] chain;
   logic              held;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   // one extra register: edge detection and a level aligned with the pointer update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= 1'b0;
      else        held <= chain[STAGES-1];
   end

   assign lvl_o  = held;
   assign rise_o = chain[STAGES-1] & ~held;

endmodule

// File: rtl/stepseq_pointer.sv
module stepseq_pointer
   import stepseq_pkg::*;
#(
   parameter int NUM_STEPS = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           adv_i,
   input  logic                           home_i,
   input  logic [MODE_BITS*NUM_STEPS-1:0] mode_i,
   output logic [NUM_STEPS-1:0]           ptr_o,
   output logic                           landed_o,
   output logic                           wrap_o
);

   localparam logic [NUM_STEPS-1:0] FIRST = NUM_STEPS'(1);
   localparam int                   LAST  = NUM_STEPS - 1;

   logic [NUM_STEPS-1:0] home_mask;
   logic [NUM_STEPS-1:0] rotated;
   logic [NUM_STEPS-1:0] next_ptr;
   logic                 home_hit;
   logic                 leaving_last;

   for (genvar i = 0; i < NUM_STEPS; i++) begin : g_home
      assign home_mask[i] = mode_homes(mode_i[MODE_BITS*i +: MODE_BITS]);
   end

   assign rotated      = {ptr_o[LAST-1:0], ptr_o[LAST]};
   assign home_hit     = |(rotated & home_mask);
   assign next_ptr     = home_hit ? FIRST : rotated;
   assign leaving_last = ptr_o[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o    <= FIRST;
         landed_o <= 1'b0;
         wrap_o   <= 1'b0;
      end else begin
         landed_o <= adv_i | home_i;
         wrap_o   <= adv_i & ~home_i & leaving_last;
         if (home_i)     ptr_o <= FIRST;
         else if (adv_i) ptr_o <= next_ptr;
      end
   end

endmodule

// File: rtl/stepseq_outputs.sv
module stepseq_outputs
   import stepseq_pkg::*;
#(
   parameter int NUM_STEPS = 16
) (
   input  logic [NUM_STEPS-1:0]           ptr_i,
   input  logic [MODE_BITS*NUM_STEPS-1:0] mode_i,
   input  logic                           tick_lvl_i,
   input  logic                           landed_i,
   input  logic                           wrap_i,
   output logic                           gate_o,
   output logic                           trig_o,
   output logic                           carry_o
);

   logic [NUM_STEPS-1:0] play_mask;
   logic                 cur_play;

   for (genvar i = 0; i < NUM_STEPS; i++) begin : g_play
      assign play_mask[i] = mode_plays(mode_i[MODE_BITS*i +: MODE_BITS]);
   end

   assign cur_play = |(ptr_i & play_mask);
   assign gate_o   = tick_lvl_i & cur_play;
   assign trig_o   = landed_i & cur_play;
   assign carry_o  = wrap_i;

endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
   import stepseq_pkg::*;
#(
   parameter int NUM_STEPS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick_in,
   input  logic                           restart_in,
   input  logic [MODE_BITS*NUM_STEPS-1:0] step_mode_i,
   output logic [NUM_STEPS-1:0]           step_onehot_o,
   output logic                           gate_o,
   output logic                           trig_o,
   output logic                           carry_o
);

   if (NUM_STEPS < 2) begin : g_bad_steps
      $error("stepseq_top: NUM_STEPS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("stepseq_top: SYNC_STAGES must be at least 2");
   end

   logic tick_lvl;
   logic tick_rise;
   logic restart_rise;
   logic restart_lvl_unused;
   logic landed;
   logic wrap;

   stepseq_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(tick_in),
      .lvl_o  (tick_lvl),
      .rise_o (tick_rise)
   );

   stepseq_sync #(.STAGES(SYNC_STAGES)) u_restart_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(restart_in),
      .lvl_o  (restart_lvl_unused),
      .rise_o (restart_rise)
   );

   stepseq_pointer #(.NUM_STEPS(NUM_STEPS)) u_pointer (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (tick_rise),
      .home_i  (restart_rise),
      .mode_i  (step_mode_i),
      .ptr_o   (step_onehot_o),
      .landed_o(landed),
      .wrap_o  (wrap)
   );

   stepseq_outputs #(.NUM_STEPS(NUM_STEPS)) u_outputs (
      .ptr_i     (step_onehot_o),
      .mode_i    (step_mode_i),
      .tick_lvl_i(tick_lvl),
      .landed_i  (landed),
      .wrap_i    (wrap),
      .gate_o    (gate_o),
      .trig_o    (trig_o),
      .carry_o   (carry_o)
   );

endmodule

// File: rtl/stepseq_checker.sv
module stepseq_checker #(
   parameter int NUM_STEPS = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_STEPS-1:0] onehot,
   input logic                 gate,
   input logic                 trig,
   input logic                 carry,
   input logic                 adv_ev,
   input logic                 home_ev
);

   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(onehot) == 1);

   a_r2_still_without_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_ev && !home_ev) |=> $stable(onehot));

   a_r6_trig_inside_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !$past(home_ev)) |-> gate);

   a_r7_carry_lands_first: assert property (@(posedge clk) disable iff (!rst_n)
      carry |-> onehot[0]);

   a_r7_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
      carry |=> !carry);

   a_r8_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
      home_ev |=> onehot[0]);

   a_r9_restart_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      home_ev |=> !carry);

endmodule

bind stepseq_top stepseq_checker #(.NUM_STEPS(NUM_STEPS)) u_stepseq_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .onehot (step_onehot_o),
   .gate   (gate_o),
   .trig   (trig_o),
   .carry  (carry_o),
   .adv_ev (tick_rise),
   .home_ev(restart_rise)
);

// File: tb/stepseq_top_bench.sv
module stepseq_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NS         = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            tick_in;
   logic            restart_in;
   logic [2*NS-1:0] mode_r;
   logic [NS-1:0]   onehot;
   logic            gate, trig, carry;

   int vectors = 0;
   int fails   = 0;
   int exp_idx = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stepseq_top #(.NUM_STEPS(NS), .SYNC_STAGES(2)) u_stepseq_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_in      (tick_in),
      .restart_in   (restart_in),
      .step_mode_i  (mode_r),
      .step_onehot_o(onehot),
      .gate_o       (gate),
      .trig_o       (trig),
      .carry_o      (carry)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit plays(input int i);
      return mode_r[2*i +: 2] == 2'b00;
   endfunction

   // one step-clock pulse held high for 4 system cycles, low for 4
   task automatic advance_one();
      int was, nxt;
      bit pl, cy, redirected;
      was = exp_idx;
      nxt = (was == NS-1) ? 0 : was + 1;
      redirected = (mode_r[2*nxt +: 2] == 2'b10);
      if (redirected) nxt = 0;
      pl = plays(nxt);
      cy = (was == NS-1);
      tick_in = 1'b1;
      repeat (3) @(negedge clk);
      if (redirected) chk("R5 jump-home target", 32'(onehot), 32'(1 << nxt));
      else            chk("R2 advance target", 32'(onehot), 32'(1 << nxt));
      chk("R3 gate by mode code", 32'(gate), 32'(pl));
      chk("R6 trig on landing", 32'(trig), 32'(pl));
      chk("R7 carry on wrap", 32'(carry), 32'(cy));
      @(negedge clk);
      chk("R6 trig one cycle", 32'(trig), 32'd0);
      chk("R7 carry one cycle", 32'(carry), 32'd0);
      tick_in = 1'b0;
      repeat (2) @(negedge clk);
      chk("R4 gate through clock-high", 32'(gate), 32'(pl));
      chk("R2 held tick advances once", 32'(onehot), 32'(1 << nxt));
      @(negedge clk);
      chk("R4 gate low after clock-high", 32'(gate), 32'd0);
      @(negedge clk);
      exp_idx = nxt;
   endtask

   task automatic restart_pulse();
      restart_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 restart to step 0", 32'(onehot), 32'd1);
      chk("R6 trig after restart", 32'(trig), 32'(plays(0)));
      chk("R7 no carry from restart", 32'(carry), 32'd0);
      @(negedge clk);
      chk("R6 restart trig one cycle", 32'(trig), 32'd0);
      exp_idx = 0;
   endtask

   initial begin
      rst_n = 1'b0; tick_in = 1'b0; restart_in = 1'b0; mode_r = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset pointer", 32'(onehot), 32'd1);
      chk("R1 reset gate", 32'(gate), 32'd0);
      chk("R1 reset trig", 32'(trig), 32'd0);
      chk("R1 reset carry", 32'(carry), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 pointer after release", 32'(onehot), 32'd1);

      // exhaustive sweep over all mode codes of a 4-step sequence
      for (int p = 0; p < (1 << (2*NS)); p++) begin
         mode_r = (2*NS)'(p);
         restart_pulse();
         if (p % 2 == 0) begin
            restart_in = 1'b0;
            repeat (4) @(negedge clk);
         end
         for (int k = 0; k < 2*NS+1; k++) advance_one();
         if (p % 2 == 1) begin
            chk("R8 held restart does not freeze", 32'(onehot), 32'(1 << exp_idx));
            restart_in = 1'b0;
            repeat (4) @(negedge clk);
         end
      end

      // restart and step edge in the same cycle, all steps playing
      mode_r = '0;
      restart_pulse();
      restart_in = 1'b0;
      repeat (4) @(negedge clk);
      advance_one();
      advance_one();
      tick_in = 1'b1;
      restart_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 restart beats advance", 32'(onehot), 32'd1);
      chk("R9 no carry on tie", 32'(carry), 32'd0);
      chk("R9 trig on tie", 32'(trig), 32'd1);
      chk("R4 gate on tie", 32'(gate), 32'd1);
      tick_in = 1'b0;
      restart_in = 1'b0;
      repeat (5) @(negedge clk);
      exp_idx = 0;

      // asynchronous reset in the middle of a run
      advance_one();
      chk("R2 moved before reset", 32'(onehot), 32'd2);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run reset pointer", 32'(onehot), 32'd1);
      chk("R1 mid-run reset gate", 32'(gate), 32'd0);
      rst_n = 1'b1;
      exp_idx = 0;
      repeat (2) @(negedge clk);
      advance_one();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule